// File: doc/BRIEF.md
# Double-Buffered Audio DMA Channel Pair

This block moves audio samples between system memory and a codec for two channels that run independently: a playback channel reads words from memory and presents them on a sample output, and a capture channel takes samples from a sample input and writes them to memory. Each channel holds a current address/count pair that is being worked through and a shadow pair that software loads ahead of time. When the current fragment runs out, the shadow pair takes over without software being involved, so buffers chain with no break in the sample stream.

Software reaches the block through a small word-wide register port. A single 32-bit control/status register holds the per-channel enable, abort, interrupt-enable, shadow-free, drained and end-of-buffer bits. It also holds a global error bit, the interrupt summary, a posted reset bit and a codec power-down bit. Memory is reached through one request/grant word port shared by both channels. A grant completes a word in the same cycle: read data and the error flag are taken when the grant is high.

A typical start loads the shadow pair, sets the enable, waits for the free flag, and loads a second fragment at once. A stop sets abort, waits for the drained flag, then clears abort and enable.

Top module: `dual_audio_dma`

## Requirements
- R1: Register addresses are 0 control/status, 1 play next address, 2 play next count (reads back play current count), 3 capture next address, 4 capture next count (reads back capture current count), 5 play current address, 6 capture current address. Writing a nonzero next count arms the pair. The channel's free flag (status bit 3 play, bit 11 capture) then reads 0 until the enabled, idle channel takes the pair as current on the next clock, after which free reads 1 again.
- R2: While a channel's free flag is 0, writes to its next address and next count registers change nothing.
- R3: When the last word of the current fragment moves and a pair is armed, that pair becomes current on the following cycle, and transfers go on in order from the new base address.
- R4: When the current count runs out with no pair armed, the channel goes idle. It stops requesting memory and stops accepting capture samples, so no earlier fragment is repeated.
- R5: The end-of-buffer cause (bit 5 play, bit 13 capture) is set at the end of a fragment only if that channel's interrupt enable (bit 2 play, bit 10 capture) is 1. Writing 1 to a cause bit or to the error bit clears it. The summary bit 23 and the irq pin are 1 while any enabled cause or the error bit is set.
- R6: With play enabled (bit 0), each word is read from the current address, the address advances by 4 and the count drops by 1. Words appear on play_data under a valid/ready handshake, in address order.
- R7: With capture enabled (bit 8), each accepted sample is written to the current capture address, and the address advances by 4 for each word.
- R8: When both channels request memory in the same cycle, the capture channel is served first.
- R9: Setting abort (bit 1 play, bit 9 capture) stops any new sample or fetch from starting. The drained flag (bit 4 play, bit 12 capture) reads 1 while abort is 1 and the channel's one-word holding register is empty. Clearing enable drops the current fragment.
- R10: Writing 1 to the reset bit (bit 24) does nothing at once. The next register access, read or write, clears both enables, aborts and interrupt enables, the causes, the error bit and codec power-down (bit 25, pin codec_pdn), and drops both armed pairs. Any write carried by that access is discarded.
- R11: If mem_err is 1 on a granted word, the error bit (bit 16) is set and an interrupt is raised.
- R12: Reading a next address register returns the last accepted value and changes no state.
- R13: A next count write uses only its low 12 bits, and a write whose low 12 bits are zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |
| codec_pdn | output | 1 | Codec power-down control |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 for memory write (capture) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant, word completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| mem_err | input | 1 | Transfer fault, valid with grant |
| play_valid | output | 1 | Play sample valid |
| play_data | output | 32 | Play sample word |
| play_ready | input | 1 | Codec takes play sample |
| cap_valid | input | 1 | Capture sample valid |
| cap_data | input | 32 | Capture sample word |
| cap_ready | output | 1 | Block takes capture sample |

## Verification
The play path is tried with a table of fragments of different bases and lengths, each with and without interrupt enable. This separates address stepping, count expiry and the gating of the end-of-buffer cause. Fragment chaining uses a long fragment followed by a short one loaded while the first runs, which shows whether the hand-over keeps word order. Capture alone, capture against play with the grant held off, abort with the codec stalled, an injected bus fault and the posted reset each cover one ordering: priority, drain, error reporting, and whether the reset is delayed and the triggering write dropped.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int NCH      = 2;
  localparam int CH_PLAY  = 0;
  localparam int CH_CAP   = 1;
  // per-channel field offsets inside the status word, channel g starts at g*CH_STRIDE
  localparam int CH_STRIDE = 8;
  localparam int F_EN      = 0;
  localparam int F_ABT     = 1;
  localparam int F_IE      = 2;
  localparam int F_FREE    = 3;
  localparam int F_DRN     = 4;
  localparam int F_EOB     = 5;
  localparam int B_ERR     = 16;
  localparam int B_PEND    = 23;
  localparam int B_RST     = 24;
  localparam int B_PDN     = 25;

  typedef struct packed {
    logic en;
    logic abort;
    logic ie;
  } chan_ctl_t;
endpackage

// File: rtl/adma_desc.sv
module adma_desc #(
  parameter int AW   = 32,
  parameter int CW   = 12,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          enable,
  input  logic          addr_we,
  input  logic          cnt_we,
  input  logic [AW-1:0] wdata,
  input  logic          beat,
  output logic          run,
  output logic          free,
  output logic          eob,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr,
  output logic [CW-1:0] cur_cnt
);
  logic          run_q, run_d, armed_q, armed_d;
  logic [AW-1:0] cur_addr_q, cur_addr_d, nxt_addr_q, nxt_addr_d;
  logic [CW-1:0] cur_cnt_q, cur_cnt_d, nxt_cnt_q, nxt_cnt_d;
  logic          promote, last;

  assign promote = enable && !run_q && armed_q;
  assign last    = beat && run_q && (cur_cnt_q == CW'(1));

  always_comb begin
    run_d      = run_q;
    armed_d    = armed_q;
    cur_addr_d = cur_addr_q;
    cur_cnt_d  = cur_cnt_q;
    nxt_addr_d = nxt_addr_q;
    nxt_cnt_d  = nxt_cnt_q;
    if (soft_clr) begin
      run_d   = 1'b0;
      armed_d = 1'b0;
    end else begin
      if (!enable) begin
        run_d = 1'b0;
      end else if (promote) begin
        run_d      = 1'b1;
        cur_addr_d = nxt_addr_q;
        cur_cnt_d  = nxt_cnt_q;
        armed_d    = 1'b0;
      end else if (beat && run_q) begin
        cur_addr_d = cur_addr_q + AW'(STEP);
        cur_cnt_d  = cur_cnt_q - CW'(1);
        if (last) run_d = 1'b0;
      end
      if (!armed_q) begin
        if (addr_we) nxt_addr_d = wdata;
        if (cnt_we && (wdata[CW-1:0] != '0)) begin
          nxt_cnt_d = wdata[CW-1:0];
          armed_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      armed_q    <= 1'b0;
      cur_addr_q <= '0;
      cur_cnt_q  <= '0;
      nxt_addr_q <= '0;
      nxt_cnt_q  <= '0;
    end else begin
      run_q      <= run_d;
      armed_q    <= armed_d;
      cur_addr_q <= cur_addr_d;
      cur_cnt_q  <= cur_cnt_d;
      nxt_addr_q <= nxt_addr_d;
      nxt_cnt_q  <= nxt_cnt_d;
    end
  end

  assign run      = run_q;
  assign free     = !armed_q;
  assign eob      = last;
  assign cur_addr = cur_addr_q;
  assign nxt_addr = nxt_addr_q;
  assign cur_cnt  = cur_cnt_q;

  // R2
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !soft_clr && !promote && (addr_we || cnt_we)) |=> ($stable(nxt_addr_q) && !free));

  // R3
  promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (promote && !soft_clr) |=> (run && free && (cur_addr == $past(nxt_addr_q))));

  // R4
  expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eob && !soft_clr) |=> !run);
endmodule

// File: rtl/adma_arb.sv
module adma_arb #(
  parameter  int N  = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic          grant_ok,
  output logic [N-1:0]  gnt,
  output logic [SW-1:0] sel,
  output logic          any
);
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        sel = SW'(i);
        any = 1'b1;
      end
    end
    gnt = '0;
    if (any && grant_ok) gnt[sel] = 1'b1;
  end
endmodule

// File: rtl/dual_audio_dma.sv
module dual_audio_dma
  import adma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          codec_pdn,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          play_valid,
  output logic [31:0]   play_data,
  input  logic          play_ready,
  input  logic          cap_valid,
  input  logic [31:0]   cap_data,
  output logic          cap_ready
);
  localparam int ARB_CAP  = 0;
  localparam int ARB_PLAY = 1;

  chan_ctl_t ctl_q [NCH];
  chan_ctl_t ctl_d [NCH];
  logic [NCH-1:0] eob_q, eob_d;
  logic err_q, err_d, pdn_q, pdn_d, rstp_q, rstp_d;
  logic pbuf_v_q, pbuf_v_d, cbuf_v_q, cbuf_v_d;
  logic [31:0] pbuf_q, pbuf_d, cbuf_q, cbuf_d;

  logic fire, wr, csr_wr, pend;
  logic [NCH-1:0] ch_en, addr_we, cnt_we, beat, run, free, eob, bufv, drn;
  logic [AW-1:0] cur_addr [NCH];
  logic [AW-1:0] nxt_addr [NCH];
  logic [CW-1:0] cur_cnt  [NCH];
  logic p_req, c_req, arb_any;
  logic [1:0] arb_req, arb_gnt;
  logic [0:0] arb_sel;
  logic [31:0] csr;

  // access decode: a posted reset swallows the next access
  assign fire   = reg_en && rstp_q;
  assign wr     = reg_en && reg_we && !rstp_q;
  assign csr_wr = wr && (reg_addr == 3'd0);
  assign addr_we[CH_PLAY] = wr && (reg_addr == 3'd1);
  assign cnt_we[CH_PLAY]  = wr && (reg_addr == 3'd2);
  assign addr_we[CH_CAP]  = wr && (reg_addr == 3'd3);
  assign cnt_we[CH_CAP]   = wr && (reg_addr == 3'd4);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign ch_en[g] = ctl_q[g].en;
      assign drn[g]   = ctl_q[g].abort && !bufv[g];
      adma_desc #(.AW(AW), .CW(CW), .STEP(4)) u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (fire),
        .enable   (ch_en[g]),
        .addr_we  (addr_we[g]),
        .cnt_we   (cnt_we[g]),
        .wdata    (reg_wdata[AW-1:0]),
        .beat     (beat[g]),
        .run      (run[g]),
        .free     (free[g]),
        .eob      (eob[g]),
        .cur_addr (cur_addr[g]),
        .nxt_addr (nxt_addr[g]),
        .cur_cnt  (cur_cnt[g])
      );
    end
  endgenerate

  assign bufv[CH_PLAY] = pbuf_v_q;
  assign bufv[CH_CAP]  = cbuf_v_q;

  // data movement requests
  assign p_req     = run[CH_PLAY] && ctl_q[CH_PLAY].en && !ctl_q[CH_PLAY].abort && !pbuf_v_q;
  assign c_req     = run[CH_CAP] && ctl_q[CH_CAP].en && cbuf_v_q;
  assign cap_ready = run[CH_CAP] && ctl_q[CH_CAP].en && !ctl_q[CH_CAP].abort && !cbuf_v_q;

  assign arb_req[ARB_CAP]  = c_req;
  assign arb_req[ARB_PLAY] = p_req;

  adma_arb #(.N(2)) u_arb (
    .req      (arb_req),
    .grant_ok (mem_gnt),
    .gnt      (arb_gnt),
    .sel      (arb_sel),
    .any      (arb_any)
  );

  assign beat[CH_PLAY] = arb_gnt[ARB_PLAY];
  assign beat[CH_CAP]  = arb_gnt[ARB_CAP];
  assign mem_req   = arb_any;
  assign mem_we    = arb_any && (arb_sel == 1'(ARB_CAP));
  assign mem_addr  = (arb_sel == 1'(ARB_CAP)) ? cur_addr[CH_CAP] : cur_addr[CH_PLAY];
  assign mem_wdata = cbuf_q;

  // holding registers, next state
  always_comb begin
    pbuf_v_d = pbuf_v_q;
    pbuf_d   = pbuf_q;
    if (fire || !ctl_q[CH_PLAY].en) begin
      pbuf_v_d = 1'b0;
    end else if (beat[CH_PLAY]) begin
      pbuf_v_d = 1'b1;
      pbuf_d   = mem_rdata;
    end else if (pbuf_v_q && play_ready) begin
      pbuf_v_d = 1'b0;
    end
    cbuf_v_d = cbuf_v_q;
    cbuf_d   = cbuf_q;
    if (fire || !ctl_q[CH_CAP].en) begin
      cbuf_v_d = 1'b0;
    end else if (cap_valid && cap_ready) begin
      cbuf_v_d = 1'b1;
      cbuf_d   = cap_data;
    end else if (beat[CH_CAP]) begin
      cbuf_v_d = 1'b0;
    end
  end

  // control/status, next state
  always_comb begin
    ctl_d  = ctl_q;
    eob_d  = eob_q;
    err_d  = err_q;
    pdn_d  = pdn_q;
    rstp_d = rstp_q;
    if (fire) begin
      for (int g = 0; g < NCH; g++) ctl_d[g] = '0;
      eob_d  = '0;
      err_d  = 1'b0;
      pdn_d  = 1'b0;
      rstp_d = 1'b0;
    end else begin
      if (csr_wr) begin
        for (int g = 0; g < NCH; g++) begin
          ctl_d[g].en    = reg_wdata[g*CH_STRIDE + F_EN];
          ctl_d[g].abort = reg_wdata[g*CH_STRIDE + F_ABT];
          ctl_d[g].ie    = reg_wdata[g*CH_STRIDE + F_IE];
          eob_d[g]       = eob_q[g] & ~reg_wdata[g*CH_STRIDE + F_EOB];
        end
        err_d  = err_q & ~reg_wdata[B_ERR];
        pdn_d  = reg_wdata[B_PDN];
        rstp_d = reg_wdata[B_RST];
      end
      for (int g = 0; g < NCH; g++) begin
        if (eob[g] && ctl_q[g].ie) eob_d[g] = 1'b1;
      end
      if (mem_req && mem_gnt && mem_err) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NCH; g++) ctl_q[g] <= '0;
      eob_q    <= '0;
      err_q    <= 1'b0;
      pdn_q    <= 1'b0;
      rstp_q   <= 1'b0;
      pbuf_v_q <= 1'b0;
      pbuf_q   <= '0;
      cbuf_v_q <= 1'b0;
      cbuf_q   <= '0;
    end else begin
      ctl_q    <= ctl_d;
      eob_q    <= eob_d;
      err_q    <= err_d;
      pdn_q    <= pdn_d;
      rstp_q   <= rstp_d;
      pbuf_v_q <= pbuf_v_d;
      pbuf_q   <= pbuf_d;
      cbuf_v_q <= cbuf_v_d;
      cbuf_q   <= cbuf_d;
    end
  end

  assign pend = (eob_q[CH_PLAY] && ctl_q[CH_PLAY].ie) ||
                (eob_q[CH_CAP] && ctl_q[CH_CAP].ie) || err_q;

  always_comb begin
    csr = '0;
    for (int g = 0; g < NCH; g++) begin
      csr[g*CH_STRIDE + F_EN]   = ctl_q[g].en;
      csr[g*CH_STRIDE + F_ABT]  = ctl_q[g].abort;
      csr[g*CH_STRIDE + F_IE]   = ctl_q[g].ie;
      csr[g*CH_STRIDE + F_FREE] = free[g];
      csr[g*CH_STRIDE + F_DRN]  = drn[g];
      csr[g*CH_STRIDE + F_EOB]  = eob_q[g];
    end
    csr[B_ERR]  = err_q;
    csr[B_PEND] = pend;
    csr[B_RST]  = rstp_q;
    csr[B_PDN]  = pdn_q;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = csr;
      3'd1:    reg_rdata = 32'(nxt_addr[CH_PLAY]);
      3'd2:    reg_rdata = 32'(cur_cnt[CH_PLAY]);
      3'd3:    reg_rdata = 32'(nxt_addr[CH_CAP]);
      3'd4:    reg_rdata = 32'(cur_cnt[CH_CAP]);
      3'd5:    reg_rdata = 32'(cur_addr[CH_PLAY]);
      3'd6:    reg_rdata = 32'(cur_addr[CH_CAP]);
      default: reg_rdata = '0;
    endcase
  end

  assign irq        = pend;
  assign codec_pdn  = pdn_q;
  assign play_valid = pbuf_v_q;
  assign play_data  = pbuf_q;

  // R8
  arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_gnt));

  // R8
  cap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req && mem_gnt) |-> (arb_gnt[ARB_CAP] && !arb_gnt[ARB_PLAY]));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CH_PLAY].abort |-> !(mem_req && !mem_we));

  // R10
  reset_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rstp_q && reg_en) |=> (!ctl_q[CH_PLAY].en && !ctl_q[CH_CAP].en && !codec_pdn && (&free)));
endmodule

// File: tb/tb_dual_audio_dma.sv
module tb_dual_audio_dma;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_en, reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, codec_pdn;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        play_valid, play_ready, cap_valid, cap_ready;
  logic [31:0] play_data, cap_data;
  logic        gnt_ok, err_inj;

  int n_chk = 0;
  int n_bad = 0;
  int rx_n  = 0;
  logic [31:0] rx   [0:255];
  logic [31:0] wmem [0:63];

  localparam logic [31:0] P_EN = 32'h1, P_ABT = 32'h2, P_IE = 32'h4, P_EOB = 32'h20;
  localparam logic [31:0] C_EN = 32'h100, C_IE = 32'h400, C_EOB = 32'h2000;
  localparam logic [31:0] ERRB = 32'h1_0000, RSTB = 32'h100_0000, PDNB = 32'h200_0000;

  // base, count, interrupt enable
  localparam logic [48:0] VEC [4] = '{
    {32'h0000_0100, 16'd1, 1'b1},
    {32'h0000_0200, 16'd3, 1'b0},
    {32'h0000_1000, 16'd6, 1'b1},
    {32'h0000_3FF0, 16'd2, 1'b1}
  };

  always #5 clk = ~clk;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3C3, a[15:0]};
  endfunction

  assign mem_gnt   = mem_req && gnt_ok;
  assign mem_rdata = mrd(mem_addr);
  assign mem_err   = err_inj;

  dual_audio_dma dut (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .codec_pdn(codec_pdn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_err(mem_err),
    .play_valid(play_valid), .play_data(play_data), .play_ready(play_ready),
    .cap_valid(cap_valid), .cap_data(cap_data), .cap_ready(cap_ready)
  );

  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we) wmem[mem_addr[7:2]] <= mem_wdata;

  always @(negedge clk)
    if (rst_n && play_valid && play_ready) begin
      rx[rx_n[7:0]] = play_data;
      rx_n = rx_n + 1;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic push_cap(input logic [31:0] d);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = d;
    #1;
    while (!cap_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int start;
    rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    play_ready = 1'b1; cap_valid = 1'b0; cap_data = '0; gnt_ok = 1'b1; err_inj = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset mem_req", {31'b0, mem_req}, 32'h0);
    chk("R10 reset pdn", {31'b0, codec_pdn}, 32'h0);
    rd(3'd0, v);
    chk("R1 reset csr", v, 32'h0000_0808);

    // table of play fragments
    for (int i = 0; i < 4; i++) begin
      logic [31:0] base;
      int cnt;
      logic ie;
      base = VEC[i][48:17];
      cnt  = int'(VEC[i][16:1]);
      ie   = VEC[i][0];
      start = rx_n;
      wr(3'd1, base);
      wr(3'd2, 32'(cnt));
      wr(3'd0, P_EN | (ie ? P_IE : 32'h0));
      repeat (cnt * 2 + 8) @(negedge clk);
      chk("R6 word count", 32'(rx_n - start), 32'(cnt));
      for (int k = 0; k < cnt; k++)
        chk("R6 word data", rx[(start + k) % 256], mrd(base + 32'(4 * k)));
      chk("R4 idle no request", {31'b0, mem_req}, 32'h0);
      chk("R5 irq follows ie", {31'b0, irq}, {31'b0, ie});
      rd(3'd0, v);
      chk("R5 eob bit", {31'b0, v[5]}, {31'b0, ie});
      chk("R1 free after run", {31'b0, v[3]}, 32'h1);
      wr(3'd0, P_EOB);
      chk("R5 w1c clears irq", {31'b0, irq}, 32'h0);
    end

    // busy writes ignored, next address readback
    start = rx_n;
    wr(3'd1, 32'h500);
    wr(3'd2, 32'd2);
    rd(3'd0, v);
    chk("R1 armed free low", {31'b0, v[3]}, 32'h0);
    wr(3'd1, 32'h900);
    wr(3'd2, 32'd5);
    rd(3'd1, v);
    chk("R12 next addr readback", v, 32'h500);
    rd(3'd1, v);
    chk("R2 next addr kept", v, 32'h500);
    wr(3'd0, P_EN);
    repeat (16) @(negedge clk);
    chk("R2 count kept", 32'(rx_n - start), 32'd2);
    chk("R2 first word", rx[start % 256], mrd(32'h500));
    wr(3'd0, 32'h0);

    // chaining
    start = rx_n;
    wr(3'd1, 32'h600);
    wr(3'd2, 32'd8);
    wr(3'd0, P_EN);
    do rd(3'd0, v); while (!v[3]);
    wr(3'd1, 32'h700);
    wr(3'd2, 32'd3);
    rd(3'd0, v);
    chk("R1 second pair armed", {31'b0, v[3]}, 32'h0);
    repeat (40) @(negedge clk);
    chk("R3 chained count", 32'(rx_n - start), 32'd11);
    for (int k = 0; k < 11; k++)
      chk("R3 chained order", rx[(start + k) % 256],
          (k < 8) ? mrd(32'h600 + 32'(4 * k)) : mrd(32'h700 + 32'(4 * (k - 8))));
    rd(3'd0, v);
    chk("R3 free after chain", {31'b0, v[3]}, 32'h1);
    wr(3'd0, 32'h0);

    // count width
    start = rx_n;
    wr(3'd1, 32'h800);
    wr(3'd2, 32'h0);
    rd(3'd0, v);
    chk("R13 zero count ignored", {31'b0, v[3]}, 32'h1);
    wr(3'd2, 32'h0001_F002);
    wr(3'd0, P_EN);
    repeat (16) @(negedge clk);
    chk("R13 low bits count", 32'(rx_n - start), 32'd2);
    wr(3'd0, 32'h0);

    // capture
    wr(3'd3, 32'h40);
    wr(3'd4, 32'd3);
    wr(3'd0, C_EN | C_IE);
    push_cap(32'hAAAA_0001);
    push_cap(32'hAAAA_0002);
    push_cap(32'hAAAA_0003);
    repeat (4) @(negedge clk);
    chk("R7 cap word0", wmem[16], 32'hAAAA_0001);
    chk("R7 cap word1", wmem[17], 32'hAAAA_0002);
    chk("R7 cap word2", wmem[18], 32'hAAAA_0003);
    chk("R4 cap idle not ready", {31'b0, cap_ready}, 32'h0);
    rd(3'd0, v);
    chk("R5 cap eob", {31'b0, v[13]}, 32'h1);
    chk("R5 cap irq", {31'b0, irq}, 32'h1);
    wr(3'd0, C_EOB);

    // arbitration
    gnt_ok = 1'b0;
    wr(3'd1, 32'h300);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'h80);
    wr(3'd4, 32'd1);
    wr(3'd0, P_EN | C_EN);
    push_cap(32'h5555_1234);
    @(negedge clk);
    chk("R8 capture served first", {mem_req, mem_we, mem_addr[29:0]}, {2'b11, 30'h80});
    gnt_ok = 1'b1;
    @(negedge clk);
    chk("R8 play after capture", {mem_req, mem_we, mem_addr[29:0]}, {2'b10, 30'h300});
    repeat (10) @(negedge clk);
    chk("R7 cap word arb", wmem[32], 32'h5555_1234);
    wr(3'd0, 32'h0);

    // abort and drain
    play_ready = 1'b0;
    wr(3'd1, 32'h400);
    wr(3'd2, 32'd4);
    wr(3'd0, P_EN);
    repeat (5) @(negedge clk);
    wr(3'd0, P_EN | P_ABT);
    rd(3'd0, v);
    chk("R9 not drained while held", {31'b0, v[4]}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 no fetch in abort", {31'b0, mem_req}, 32'h0);
    play_ready = 1'b1;
    @(negedge clk);
    play_ready = 1'b0;
    rd(3'd0, v);
    chk("R9 drained", {31'b0, v[4]}, 32'h1);
    chk("R9 still quiet", {31'b0, mem_req}, 32'h0);
    wr(3'd0, 32'h0);
    play_ready = 1'b1;

    // bus error
    err_inj = 1'b1;
    wr(3'd1, 32'h100);
    wr(3'd2, 32'd1);
    wr(3'd0, P_EN);
    repeat (6) @(negedge clk);
    err_inj = 1'b0;
    rd(3'd0, v);
    chk("R11 error bit", {31'b0, v[16]}, 32'h1);
    chk("R11 error irq", {31'b0, irq}, 32'h1);
    wr(3'd0, ERRB);
    chk("R5 error w1c", {31'b0, irq}, 32'h0);

    // posted reset
    wr(3'd1, 32'hABC0);
    wr(3'd2, 32'd1);
    wr(3'd0, PDNB | C_IE);
    chk("R10 pdn set", {31'b0, codec_pdn}, 32'h1);
    wr(3'd0, RSTB | PDNB | C_IE);
    repeat (3) @(negedge clk);
    chk("R10 reset waits", {31'b0, codec_pdn}, 32'h1);
    wr(3'd1, 32'h5550);
    chk("R10 reset applied pdn", {31'b0, codec_pdn}, 32'h0);
    rd(3'd0, v);
    chk("R10 csr after reset", v, 32'h0000_0808);
    rd(3'd1, v);
    chk("R10 trigger write dropped", v, 32'hABC0);

    finish_run();
  end
endmodule